// File: doc/BRIEF.md
# Tagged reservation station cluster

This block holds the operations waiting for, or running in, a small group of floating-point adder and multiplier units. Each operation comes in with two source register indices and one destination index. While it sits in a station, each source is either a captured value or the tag of the station that will produce that value. A register status table maps every architectural register to the tag of its pending producer. Renaming is done at issue by writing the new station's tag into the destination's status entry.

Finished results leave over one shared result bus, at most one per cycle. Every station still waiting for that tag takes the value from the bus, and so does every register whose status still names that tag. The arithmetic runs as a fixed-latency pipeline inside each station. Each station is a four-state machine:

- FREE --allocate, both operands present--> EXEC
- FREE --allocate, an operand missing--> WAIT
- WAIT --last operand snooped--> EXEC
- EXEC --latency counter expires--> DONE
- DONE --bus granted--> FREE

Top module: `rs_cluster`

## Requirements
- R1: After reset every register status tag is 0, register i holds the value i+1, no broadcast is driven, and `iss_ready` is 1 for both operation kinds.
- R2: `iss_kind` 0 selects the adder class (station tags 1 to 3) and 1 selects the multiplier class (tags 4 and 5). The lowest-numbered free station of that class is taken, and the destination's status tag becomes that station's tag at the issue edge.
- R3: `iss_ready` is 0 when the selected class has no FREE station. An issue presented while `iss_ready` is 0 changes no register status.
- R4: A source whose status tag is 0 is captured as a value at issue. A later write to that register does not change the value already held by the waiting operation.
- R5: A newer issue to the same destination replaces the status tag. A broadcast from the older producer then leaves that register unchanged.
- R6: At most one result is broadcast per cycle, with a tag in 1..5. Its data is the sum modulo 2^16 (adder) or the low 16 bits of the product (multiplier) of the two operands.
- R7: When several stations are in DONE together, the lowest tag is granted first. The others keep requesting until they are granted.
- R8: On a broadcast, every register whose status tag equals the bus tag takes the bus data and its tag returns to 0.
- R9: A station is FREE in the cycle after its broadcast and can be allocated again.
- R10: A source whose producer broadcasts in the same cycle as the issue takes the bus data at issue and does not wait.
- R11: With no bus contention, an operation issued with both operands present drives the bus in the cycle after edge k+LAT, where k is its issue edge. LAT is 2 for adds and 3 for multiplies.
- R12: After the cluster drains, every register holds the value that in-order execution of the issued operations gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_kind | input | 1 | 0 add, 1 multiply |
| iss_src_a | input | 3 | First source register index |
| iss_src_b | input | 3 | Second source register index |
| iss_dst | input | 3 | Destination register index |
| iss_ready | output | 1 | A free station of the offered kind exists |
| bus_valid | output | 1 | A result is broadcast this cycle |
| bus_tag | output | 4 | Tag of the broadcasting station |
| bus_data | output | 16 | Broadcast result value |
| rd_idx | input | 3 | Register index to observe |
| rd_data | output | 16 | Value of register `rd_idx` |
| rd_tag | output | 4 | Pending producer tag of register `rd_idx`, 0 if none |

## Verification
Directed sequences are used first.

- Three adds wait on one multiply. This fills the adder class, which exposes the issue stall, and makes all three adds finish in the same cycle, which shows the bus priority order.
- A multiply followed by a faster add to the same register separates renaming from a plain last-broadcast-wins update.
- An overwrite of a source register after its consumer issued shows whether operands were copied at issue.
- An issue timed onto the cycle its producer broadcasts catches a missing bypass, because the consumer would then wait forever.

A long run of random operations with random gaps then checks every broadcast value and the final register contents against an in-order model.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int TAG_W = 4;
    typedef logic [TAG_W-1:0] tag_t;
    localparam tag_t NO_TAG = '0;
    typedef enum logic [1:0] {ST_FREE, ST_WAIT, ST_EXEC, ST_DONE} rs_state_e;
endpackage

// File: rtl/rs_prio_pick.sv
module rs_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic taken;

    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat import rs_pkg::*; #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    input  logic [IW-1:0] rb_idx,
    input  logic [IW-1:0] rc_idx,
    output logic [DW-1:0] ra_val,
    output tag_t          ra_tag,
    output logic [DW-1:0] rb_val,
    output tag_t          rb_tag,
    output logic [DW-1:0] rc_val,
    output tag_t          rc_tag,
    input  logic          ren_en,
    input  logic [IW-1:0] ren_idx,
    input  tag_t          ren_tag,
    input  logic          bus_valid,
    input  tag_t          bus_tag,
    input  logic [DW-1:0] bus_data
);
    logic [DW-1:0] val_w [NREG];
    tag_t          tag_w [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] v_q;
        tag_t          t_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= DW'(g + 1);
                t_q <= NO_TAG;
            end else if (ren_en && ren_idx == IW'(g)) begin
                t_q <= ren_tag;
            end else if (bus_valid && t_q != NO_TAG && t_q == bus_tag) begin
                v_q <= bus_data;
                t_q <= NO_TAG;
            end
        end

        assign val_w[g] = v_q;
        assign tag_w[g] = t_q;
    end

    assign ra_val = val_w[ra_idx];
    assign ra_tag = tag_w[ra_idx];
    assign rb_val = val_w[rb_idx];
    assign rb_tag = tag_w[rb_idx];
    assign rc_val = val_w[rc_idx];
    assign rc_tag = tag_w[rc_idx];
endmodule

// File: rtl/rs_station.sv
module rs_station import rs_pkg::*; #(
    parameter int DW     = 16,
    parameter int LAT    = 2,
    parameter bit IS_MUL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [DW-1:0] a_val,
    input  tag_t          a_tag,
    input  logic [DW-1:0] b_val,
    input  tag_t          b_tag,
    input  logic          bus_valid,
    input  tag_t          bus_tag,
    input  logic [DW-1:0] bus_data,
    input  logic          grant,
    output logic          free,
    output logic          req,
    output logic [DW-1:0] result
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    rs_state_e     state_q, state_n;
    logic [DW-1:0] opa_q, opa_n, opb_q, opb_n, res_q, res_n, op_out;
    tag_t          qa_q, qa_n, qb_q, qb_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          hit_a, hit_b;

    if (IS_MUL) begin : g_mul
        assign op_out = opa_q * opb_q;
    end else begin : g_add
        assign op_out = opa_q + opb_q;
    end

    assign hit_a = bus_valid && (qa_q != NO_TAG) && (qa_q == bus_tag);
    assign hit_b = bus_valid && (qb_q != NO_TAG) && (qb_q == bus_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            opa_q   <= '0;
            opb_q   <= '0;
            qa_q    <= NO_TAG;
            qb_q    <= NO_TAG;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            state_q <= state_n;
            opa_q   <= opa_n;
            opb_q   <= opb_n;
            qa_q    <= qa_n;
            qb_q    <= qb_n;
            cnt_q   <= cnt_n;
            res_q   <= res_n;
        end
    end

    always_comb begin
        state_n = state_q;
        opa_n   = opa_q;
        opb_n   = opb_q;
        qa_n    = qa_q;
        qb_n    = qb_q;
        cnt_n   = cnt_q;
        res_n   = res_q;
        unique case (state_q)
            ST_FREE: begin
                if (alloc) begin
                    opa_n = a_val;
                    qa_n  = a_tag;
                    opb_n = b_val;
                    qb_n  = b_tag;
                    if (a_tag == NO_TAG && b_tag == NO_TAG) begin
                        state_n = ST_EXEC;
                        cnt_n   = CW'(LAT - 1);
                    end else begin
                        state_n = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (hit_a) begin
                    opa_n = bus_data;
                    qa_n  = NO_TAG;
                end
                if (hit_b) begin
                    opb_n = bus_data;
                    qb_n  = NO_TAG;
                end
                if (qa_n == NO_TAG && qb_n == NO_TAG) begin
                    state_n = ST_EXEC;
                    cnt_n   = CW'(LAT - 1);
                end
            end
            ST_EXEC: begin
                if (cnt_q == '0) begin
                    state_n = ST_DONE;
                    res_n   = op_out;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            ST_DONE: begin
                if (grant) state_n = ST_FREE;
            end
        endcase
    end

    assign free   = (state_q == ST_FREE);
    assign req    = (state_q == ST_DONE);
    assign result = res_q;
endmodule

// File: rtl/rs_cluster.sv
module rs_cluster import rs_pkg::*; #(
    parameter int NREG    = 8,
    parameter int DW      = 16,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3,
    localparam int IW     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic             iss_kind,
    input  logic [IW-1:0]    iss_src_a,
    input  logic [IW-1:0]    iss_src_b,
    input  logic [IW-1:0]    iss_dst,
    output logic             iss_ready,
    output logic             bus_valid,
    output logic [TAG_W-1:0] bus_tag,
    output logic [DW-1:0]    bus_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int NST = N_ADD + N_MUL;

    logic [DW-1:0]  ra_val, rb_val, opa_val, opb_val;
    tag_t           ra_tag, rb_tag, opa_tag, opb_tag, new_tag;
    logic [NST-1:0] st_free, st_req, bus_grant, st_alloc;
    logic [N_ADD-1:0] pick_add;
    logic [N_MUL-1:0] pick_mul;
    logic [DW-1:0]  st_res [NST];
    logic           fire;

    rs_regstat #(.NREG(NREG), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(iss_src_a), .rb_idx(iss_src_b), .rc_idx(rd_idx),
        .ra_val(ra_val), .ra_tag(ra_tag),
        .rb_val(rb_val), .rb_tag(rb_tag),
        .rc_val(rd_data), .rc_tag(rd_tag),
        .ren_en(fire), .ren_idx(iss_dst), .ren_tag(new_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    // Operand read with same-cycle bypass from the result bus
    always_comb begin
        opa_val = ra_val;
        opa_tag = ra_tag;
        opb_val = rb_val;
        opb_tag = rb_tag;
        if (bus_valid && ra_tag != NO_TAG && ra_tag == bus_tag) begin
            opa_val = bus_data;
            opa_tag = NO_TAG;
        end
        if (bus_valid && rb_tag != NO_TAG && rb_tag == bus_tag) begin
            opb_val = bus_data;
            opb_tag = NO_TAG;
        end
    end

    rs_prio_pick #(.N(N_ADD)) u_pick_add (.req(st_free[N_ADD-1:0]), .gnt(pick_add));
    rs_prio_pick #(.N(N_MUL)) u_pick_mul (.req(st_free[NST-1:N_ADD]), .gnt(pick_mul));

    assign iss_ready = iss_kind ? |st_free[NST-1:N_ADD] : |st_free[N_ADD-1:0];
    assign fire      = iss_valid && iss_ready;
    assign st_alloc  = !fire    ? '0 :
                       iss_kind ? {pick_mul, {N_ADD{1'b0}}} : {{N_MUL{1'b0}}, pick_add};

    always_comb begin
        new_tag = NO_TAG;
        for (int s = 0; s < NST; s++) begin
            if (st_alloc[s]) new_tag = tag_t'(s + 1);
        end
    end

    rs_prio_pick #(.N(NST)) u_bus_arb (.req(st_req), .gnt(bus_grant));

    assign bus_valid = |st_req;
    always_comb begin
        bus_tag  = NO_TAG;
        bus_data = '0;
        for (int s = 0; s < NST; s++) begin
            if (bus_grant[s]) begin
                bus_tag  = tag_t'(s + 1);
                bus_data = st_res[s];
            end
        end
    end

    for (genvar s = 0; s < NST; s++) begin : g_st
        rs_station #(
            .DW(DW),
            .LAT((s < N_ADD) ? ADD_LAT : MUL_LAT),
            .IS_MUL(s >= N_ADD)
        ) u_st (
            .clk(clk), .rst_n(rst_n), .alloc(st_alloc[s]),
            .a_val(opa_val), .a_tag(opa_tag), .b_val(opb_val), .b_tag(opb_tag),
            .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
            .grant(bus_grant[s]), .free(st_free[s]), .req(st_req[s]),
            .result(st_res[s])
        );
    end
endmodule

// File: rtl/rs_cluster_chk.sv
module rs_cluster_chk import rs_pkg::*; #(
    parameter int NST = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           iss_valid,
    input logic           iss_ready,
    input logic [NST-1:0] st_free,
    input logic [NST-1:0] st_req,
    input logic [NST-1:0] bus_grant,
    input logic           bus_valid,
    input tag_t           bus_tag
);
    assert_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != NO_TAG && int'(bus_tag) <= NST));

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_grant));

    assert_grant_when_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> $countones(bus_grant) == 1);

    // R3: stations only leave FREE through an accepted issue and return through a grant
    assert_free_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_free) == $countones($past(st_free)) + $countones($past(bus_grant))
                               - int'($past(iss_valid && iss_ready)));

    for (genvar i = 0; i < NST; i++) begin : g_st
        assert_loser_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_req[i] && !bus_grant[i]) |=> st_req[i]);
        assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
            bus_grant[i] |=> st_free[i]);
    end
endmodule

bind rs_cluster rs_cluster_chk #(.NST(N_ADD + N_MUL)) u_rs_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .st_free(st_free), .st_req(st_req), .bus_grant(bus_grant),
    .bus_valid(bus_valid), .bus_tag(bus_tag)
);

// File: tb/rs_cluster_test.sv
module rs_cluster_test;
    localparam int NREG = 8, DW = 16, ADD_LAT = 2, MUL_LAT = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        iss_valid = 1'b0, iss_kind = 1'b0;
    logic [2:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0, rd_idx = '0;
    logic        iss_ready, bus_valid;
    logic [3:0]  bus_tag, rd_tag, last_tag;
    logic [15:0] bus_data, rd_data;
    int          n_chk = 0, n_bad = 0, log_n = 0;
    bit          log_en = 1'b0;
    int          log_tag [32];
    logic [15:0] ref_reg [NREG];
    logic [15:0] exp_res [16];

    rs_cluster #(.NREG(NREG), .DW(DW), .N_ADD(3), .N_MUL(2),
                 .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_kind(iss_kind),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .iss_ready(iss_ready), .bus_valid(bus_valid), .bus_tag(bus_tag),
        .bus_data(bus_data), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_op(input bit k, input logic [15:0] x, input logic [15:0] y);
        return k ? x * y : x + y;
    endfunction

    // R6: every broadcast carries the result the in-order model predicts for that tag
    always @(negedge clk) begin
        if (rst_n && bus_valid) begin
            chk(bus_data == exp_res[bus_tag], "R6", "bus data", bus_data, exp_res[bus_tag]);
            if (log_en && log_n < 32) begin
                log_tag[log_n] = int'(bus_tag);
                log_n++;
            end
        end
    end

    task automatic issue_now(input bit k, input int a, input int b, input int d);
        logic [15:0] r;
        iss_valid = 1'b1; iss_kind = k;
        iss_src_a = 3'(a); iss_src_b = 3'(b); iss_dst = 3'(d);
        #1;
        while (!iss_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        iss_valid = 1'b0;
        rd_idx = 3'(d); #1;
        last_tag = rd_tag;
        r = ref_op(k, ref_reg[a], ref_reg[b]);
        exp_res[rd_tag] = r;
        ref_reg[d] = r;
    endtask

    task automatic issue(input bit k, input int a, input int b, input int d);
        @(negedge clk);
        issue_now(k, a, b, d);
    endtask

    task automatic drain();
        repeat (60) @(negedge clk);
    endtask

    task automatic check_regs(input string rq);
        for (int i = 0; i < NREG; i++) begin
            rd_idx = 3'(i); #1;
            chk(rd_tag == 4'd0, rq, "register tag", rd_tag, 0);
            chk(rd_data == ref_reg[i], rq, "register value", rd_data, ref_reg[i]);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < NREG; i++) ref_reg[i] = 16'(i + 1);
        for (int i = 0; i < 16; i++) exp_res[i] = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        iss_kind = 1'b0; #1;
        chk(iss_ready == 1'b1, "R1", "ready add", iss_ready, 1);
        iss_kind = 1'b1; #1;
        chk(iss_ready == 1'b1, "R1", "ready mul", iss_ready, 1);
        chk(bus_valid == 1'b0, "R1", "bus idle", bus_valid, 0);
        check_regs("R1");

        // R2 allocation, R3 stall, R7 priority
        log_en = 1'b1; log_n = 0;
        issue(1'b1, 1, 2, 0); chk(last_tag == 4'd4, "R2", "mul tag", last_tag, 4);
        issue(1'b0, 0, 1, 3); chk(last_tag == 4'd1, "R2", "add tag 1", last_tag, 1);
        issue(1'b0, 0, 2, 4); chk(last_tag == 4'd2, "R2", "add tag 2", last_tag, 2);
        issue(1'b0, 0, 0, 5); chk(last_tag == 4'd3, "R2", "add tag 3", last_tag, 3);
        @(negedge clk);
        iss_kind = 1'b0; iss_src_a = 3'd1; iss_src_b = 3'd2; iss_dst = 3'd6; iss_valid = 1'b1;
        #1;
        chk(iss_ready == 1'b0, "R3", "ready with adders full", iss_ready, 0);
        @(posedge clk); #1;
        iss_valid = 1'b0;
        rd_idx = 3'd6; #1;
        chk(rd_tag == 4'd0, "R3", "ignored issue tag", rd_tag, 0);
        chk(rd_data == 16'd7, "R3", "ignored issue value", rd_data, 7);
        drain();
        log_en = 1'b0;
        chk(log_n == 4, "R7", "broadcast count", log_n, 4);
        chk(log_tag[0] == 4, "R7", "first tag", log_tag[0], 4);
        chk(log_tag[1] == 1, "R7", "second tag", log_tag[1], 1);
        chk(log_tag[2] == 2, "R7", "third tag", log_tag[2], 2);
        chk(log_tag[3] == 3, "R7", "fourth tag", log_tag[3], 3);
        check_regs("R8");
        @(negedge clk);
        iss_kind = 1'b0; #1;
        chk(iss_ready == 1'b1, "R9", "adders released", iss_ready, 1);
        iss_kind = 1'b1; #1;
        chk(iss_ready == 1'b1, "R9", "multipliers released", iss_ready, 1);

        // R5 WAW: slow multiply then fast add to r2
        issue(1'b1, 3, 3, 2);
        issue(1'b0, 1, 1, 2);
        chk(last_tag == 4'd1, "R5", "newest producer tag", last_tag, 1);
        drain();
        check_regs("R5");

        // R4 WAR: consumer waits while its other source is overwritten
        issue(1'b1, 3, 3, 0);
        issue(1'b0, 0, 2, 1);
        issue(1'b0, 5, 5, 2);
        drain();
        check_regs("R4");

        // R11 latency without contention
        issue(1'b0, 2, 3, 1);
        n = 0;
        do begin @(negedge clk); n++; end while (!bus_valid && n < 20);
        chk(n == ADD_LAT + 1, "R11", "add latency", n, ADD_LAT + 1);
        drain();
        issue(1'b1, 2, 3, 4);
        n = 0;
        do begin @(negedge clk); n++; end while (!bus_valid && n < 20);
        chk(n == MUL_LAT + 1, "R11", "mul latency", n, MUL_LAT + 1);
        drain();

        // R10 issue in the very cycle the producer broadcasts
        issue(1'b1, 1, 1, 7);
        n = 0;
        do begin @(negedge clk); #1; n++; end
        while (!(bus_valid && bus_tag == last_tag) && n < 20);
        issue_now(1'b0, 7, 7, 6);
        drain();
        check_regs("R10");

        // R12 random stream against the in-order model
        for (int k = 0; k < 300; k++) begin
            bit kd;
            int a, b, d;
            kd = 1'($urandom % 2);
            a  = int'($urandom % 8);
            b  = int'($urandom % 8);
            d  = int'($urandom % 8);
            repeat ($urandom % 3) @(negedge clk);
            issue(kd, a, b, d);
        end
        drain();
        check_regs("R12");

        summary();
        $finish;
    end
endmodule